// File: doc/BRIEF.md
# Presettable Down Counter Channel with Latched Readback

This block is one 16-bit down counter channel for a timer subsystem. A system clock runs the logic. A single-cycle strobe, `cnt_tick`, marks each counting edge, and a `gate` level qualifies or triggers counting. Software talks to the block through two byte-wide access points: a control strobe that takes a command byte and a data strobe pair that writes or reads count bytes. The counter can count in binary or in four-digit BCD. It supports four waveform modes: terminal-count output, retriggerable one-shot, rate generator and square wave. For a 32-bit chain, instantiate two channels and use the output of the first as the tick source of the second.

Reads can be taken from the live count or from a frozen copy. A latch command copies the count into a holding register. That copy is kept until software has read all of its bytes. A readback command can capture the count, a status byte, or both. When both are captured, the status byte comes out first.

The counter core is a four-state machine:
- `ST_IDLE`: the state after reset or after a control write; no count is present.
- `ST_WAIT_LOAD`: a count has been written and is moved into the counter on the next tick.
- `ST_WAIT_TRIG`: the one-shot mode has a count and is waiting for a gate rising edge.
- `ST_RUN`: counting.

The transitions are:
- control write: any state goes to `ST_IDLE`.
- count write: `ST_IDLE` goes to `ST_WAIT_LOAD`, or to `ST_WAIT_TRIG` in the one-shot mode. In the terminal-count mode, any state goes to `ST_WAIT_LOAD`.
- tick: `ST_WAIT_LOAD` goes to `ST_RUN`.
- tick with a pending trigger: `ST_WAIT_TRIG` goes to `ST_RUN`.

Top module: `ctr_channel`

## Requirements
- R1: A control byte with bits [7:6] not 11 and bits [5:4] not 00 programs the channel. Bits [5:4] select the access: 01 is low byte only, 10 is high byte only, 11 is low byte then high byte. In the 01 and 10 settings, the byte not accessed loads as zero. Data reads follow the same setting: 01 returns the low byte, 10 returns the high byte, and 11 returns low then high.
- R2: Bit 0 of the control byte selects binary counting (0) or four-digit BCD counting (1). In BCD, 0x0010 decrements to 0x0009.
- R3: A control byte with bits [7:6] not 11 and bits [5:4] = 00 latches the count. The held value stays frozen while the live count moves on. Further latch commands have no effect until every byte of the held value has been read. After that, reads return the live count again.
- R4: A control byte with bits [7:6] = 11 is a readback command, and it acts only when bit 1 is set. Bit 5 = 0 latches the count and bit 4 = 0 latches the status. When both are latched, reads return the status, then the low count byte, then the high count byte.
- R5: The status byte is {output level, null-count, access[1:0], mode[2:0], bcd}. Null-count is set by a control write or a count write. It is cleared when the count is moved into the counter. After reset the status byte reads 0x80.
- R6: Mode 0: the output goes low when a count N is written. It goes high N ticks after the load tick and stays high until the next write.
- R7: Mode 1: a gate rising edge arms the load. On the next tick the output goes low, and it returns high N ticks later. A new rising edge before the end reloads N and restarts the low time.
- R8: Mode 2: k ticks after the load tick, the output is low exactly when k mod N = N-1, and the count is N - (k mod N).
- R9: Mode 3: k ticks after the load tick, the output is high when (k mod N) < (N+1)/2 and low otherwise. An odd N therefore gives (N+1)/2 high ticks and (N-1)/2 low ticks.
- R10: In modes 0, 2 and 3, ticks while the gate is low leave the count unchanged. In modes 2 and 3, a gate rising edge reloads N on the next tick.
- R11: After reset the output is high, the count reads zero and the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | One-cycle strobe marking a counting edge |
| gate | input | 1 | Gate level; enables counting or triggers, depending on mode |
| ctl_wr | input | 1 | Strobe: `din` holds a control, latch or readback byte |
| dat_wr | input | 1 | Strobe: `din` holds a count byte |
| dat_rd | input | 1 | Strobe: advance past the byte shown on `dout` |
| din | input | 8 | Write data |
| dout | output | 8 | Byte that the next read returns |
| out | output | 1 | Counter output |

## Verification
The hardest situations to reach from the ports are an ignored second latch and a readback that captures both status and count. Both need the live count to keep moving while a frozen copy is pending. The stimulus therefore issues a latch, runs further ticks, issues another latch and only then drains the bytes. A final live read shows that the later count was never captured. Retriggering the one-shot needs a gate edge to arrive while the low pulse is still running, so the bench places the edge one tick before the pulse would end. Randomly sized counts and tick runs then compare latched values in binary, in BCD and across rate-generator reloads against values the bench computes.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int DIGITS  = CNT_W / 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_LOAD,
        ST_WAIT_TRIG,
        ST_RUN
    } ctr_state_t;

    localparam logic [1:0] RW_LATCH = 2'b00;
    localparam logic [1:0] RW_LSB   = 2'b01;
    localparam logic [1:0] RW_MSB   = 2'b10;
    localparam logic [1:0] RW_PAIR  = 2'b11;

    localparam logic [1:0] M_TC   = 2'd0;
    localparam logic [1:0] M_OS   = 2'd1;
    localparam logic [1:0] M_RATE = 2'd2;
    localparam logic [1:0] M_SQ   = 2'd3;

    // one step down, binary or BCD
    function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic borrow;
        r = v;
        borrow = 1'b1;
        if (!bcd) begin
            r = v - 1'b1;
        end else begin
            for (int i = 0; i < DIGITS; i++) begin
                if (borrow) begin
                    if (r[4*i +: 4] == 4'd0) begin
                        r[4*i +: 4] = 4'd9;
                    end else begin
                        r[4*i +: 4] = r[4*i +: 4] - 4'd1;
                        borrow = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction

    // one step up, binary or BCD
    function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic carry;
        r = v;
        carry = 1'b1;
        if (!bcd) begin
            r = v + 1'b1;
        end else begin
            for (int i = 0; i < DIGITS; i++) begin
                if (carry) begin
                    if (r[4*i +: 4] >= 4'd9) begin
                        r[4*i +: 4] = 4'd0;
                    end else begin
                        r[4*i +: 4] = r[4*i +: 4] + 4'd1;
                        carry = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/ctr_gate_edge.sv
module ctr_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate;
    end

    assign rise = gate & ~gate_q;
endmodule

// File: rtl/ctr_access.sv
module ctr_access
    import ctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] din,
    input  logic [CNT_W-1:0]  count,
    input  logic              out,
    input  logic              null_cnt,
    output logic              cfg_wr,
    output logic [1:0]        mode_lo,
    output logic              bcd,
    output logic              val_wr,
    output logic [CNT_W-1:0]  val,
    output logic [BYTE_W-1:0] dout
);
    logic [1:0]        rw_q;
    logic [2:0]        mode_q;
    logic              bcd_q;
    logic              wr_hi_q;
    logic [BYTE_W-1:0] lo_q;
    logic              rd_hi_q;
    logic              cnt_lat_q;
    logic [CNT_W-1:0]  hold_q;
    logic              st_lat_q;
    logic [BYTE_W-1:0] st_hold_q;

    logic              is_rb;
    logic              is_latch;
    logic [BYTE_W-1:0] status;
    logic [CNT_W-1:0]  src;
    logic              sel_hi;
    logic              last_byte;

    assign is_rb    = (din[7:6] == 2'b11);
    assign is_latch = !is_rb && (din[5:4] == RW_LATCH);
    assign cfg_wr   = ctl_wr && !is_rb && !is_latch;
    assign mode_lo  = mode_q[1:0];
    assign bcd      = bcd_q;
    assign status   = {out, null_cnt, rw_q, mode_q, bcd_q};

    // count assembly for the write side
    always_comb begin
        val_wr = 1'b0;
        val    = '0;
        if (dat_wr) begin
            unique case (rw_q)
                RW_LSB:   begin val_wr = 1'b1; val = {{BYTE_W{1'b0}}, din}; end
                RW_MSB:   begin val_wr = 1'b1; val = {din, {BYTE_W{1'b0}}}; end
                RW_PAIR:  begin val_wr = wr_hi_q; val = {din, lo_q}; end
                RW_LATCH: begin end
            endcase
        end
    end

    // read byte selection
    always_comb begin
        src       = cnt_lat_q ? hold_q : count;
        sel_hi    = (rw_q == RW_MSB) || ((rw_q == RW_PAIR) && rd_hi_q);
        last_byte = (rw_q != RW_PAIR) || rd_hi_q;
        dout      = st_lat_q ? st_hold_q : (sel_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q      <= RW_LATCH;
            mode_q    <= 3'd0;
            bcd_q     <= 1'b0;
            wr_hi_q   <= 1'b0;
            lo_q      <= '0;
            rd_hi_q   <= 1'b0;
            cnt_lat_q <= 1'b0;
            hold_q    <= '0;
            st_lat_q  <= 1'b0;
            st_hold_q <= '0;
        end else if (ctl_wr) begin
            if (is_rb) begin
                if (din[1]) begin
                    if (!din[5] && !cnt_lat_q) begin
                        hold_q    <= count;
                        cnt_lat_q <= 1'b1;
                    end
                    if (!din[4] && !st_lat_q) begin
                        st_hold_q <= status;
                        st_lat_q  <= 1'b1;
                    end
                end
            end else if (is_latch) begin
                if (!cnt_lat_q) begin
                    hold_q    <= count;
                    cnt_lat_q <= 1'b1;
                end
            end else begin
                rw_q      <= din[5:4];
                mode_q    <= din[3:1];
                bcd_q     <= din[0];
                wr_hi_q   <= 1'b0;
                rd_hi_q   <= 1'b0;
                cnt_lat_q <= 1'b0;
                st_lat_q  <= 1'b0;
            end
        end else begin
            if (dat_wr && rw_q == RW_PAIR) begin
                if (!wr_hi_q) lo_q <= din;
                wr_hi_q <= ~wr_hi_q;
            end
            if (dat_rd) begin
                if (st_lat_q) begin
                    st_lat_q <= 1'b0;
                end else begin
                    if (rw_q == RW_PAIR) rd_hi_q <= ~rd_hi_q;
                    if (cnt_lat_q && last_byte) cnt_lat_q <= 1'b0;
                end
            end
        end
    end

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_lat_q && !ctl_wr && !dat_rd) |=> $stable(dout)); // R3
endmodule

// File: rtl/ctr_core.sv
module ctr_core
    import ctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             gate_rise,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       mode,
    input  logic             bcd,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] val,
    output logic [CNT_W-1:0] count,
    output logic             out,
    output logic             null_cnt
);
    ctr_state_t       state_q, state_d;
    logic [CNT_W-1:0] count_q, init_q;
    logic             out_q, null_q, trig_q;
    logic [CNT_W-1:0] dec1, dec2, hi_val, lo_val;

    assign count    = count_q;
    assign out      = out_q;
    assign null_cnt = null_q;

    always_comb begin
        dec1   = step_down(count_q, bcd);
        dec2   = step_down(dec1, bcd);
        hi_val = init_q[0] ? step_up(init_q, bcd)   : init_q;
        lo_val = init_q[0] ? step_down(init_q, bcd) : init_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            state_d = ST_IDLE;
        end else if (val_wr) begin
            if (mode == M_OS) begin
                if (state_q != ST_RUN) state_d = ST_WAIT_TRIG;
            end else if (mode == M_TC || state_q == ST_IDLE) begin
                state_d = ST_WAIT_LOAD;
            end
        end else if (tick) begin
            if (state_q == ST_WAIT_LOAD)                state_d = ST_RUN;
            else if (state_q == ST_WAIT_TRIG && trig_q) state_d = ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            init_q  <= '0;
            out_q   <= 1'b1;
            null_q  <= 1'b0;
            trig_q  <= 1'b0;
        end else if (cfg_wr) begin
            out_q  <= (cfg_mode != M_TC);
            null_q <= 1'b1;
            trig_q <= 1'b0;
        end else begin
            if (gate_rise && mode != M_TC) trig_q <= 1'b1;
            if (val_wr) begin
                init_q <= val;
                null_q <= 1'b1;
                if (mode == M_TC) out_q <= 1'b0;
            end else if (tick) begin
                unique case (state_q)
                    ST_IDLE: begin end
                    ST_WAIT_LOAD: begin
                        count_q <= (mode == M_SQ) ? hi_val : init_q;
                        out_q   <= (mode != M_TC);
                        null_q  <= 1'b0;
                        trig_q  <= 1'b0;
                    end
                    ST_WAIT_TRIG: begin
                        if (trig_q) begin
                            count_q <= init_q;
                            out_q   <= 1'b0;
                            null_q  <= 1'b0;
                            trig_q  <= 1'b0;
                        end
                    end
                    ST_RUN: begin
                        unique case (mode)
                            M_TC: begin
                                if (gate) begin
                                    count_q <= dec1;
                                    if (count_q == {{(CNT_W-1){1'b0}}, 1'b1}) out_q <= 1'b1;
                                end
                            end
                            M_OS: begin
                                if (trig_q) begin
                                    count_q <= init_q;
                                    out_q   <= 1'b0;
                                    null_q  <= 1'b0;
                                    trig_q  <= 1'b0;
                                end else begin
                                    count_q <= dec1;
                                    if (count_q == {{(CNT_W-1){1'b0}}, 1'b1}) out_q <= 1'b1;
                                end
                            end
                            M_RATE: begin
                                if (trig_q) begin
                                    count_q <= init_q;
                                    out_q   <= 1'b1;
                                    null_q  <= 1'b0;
                                    trig_q  <= 1'b0;
                                end else if (gate) begin
                                    if (count_q == {{(CNT_W-2){1'b0}}, 2'd2}) begin
                                        out_q   <= 1'b0;
                                        count_q <= dec1;
                                    end else if (count_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                                        out_q   <= 1'b1;
                                        count_q <= init_q;
                                        null_q  <= 1'b0;
                                    end else begin
                                        count_q <= dec1;
                                    end
                                end
                            end
                            M_SQ: begin
                                if (trig_q) begin
                                    count_q <= hi_val;
                                    out_q   <= 1'b1;
                                    null_q  <= 1'b0;
                                    trig_q  <= 1'b0;
                                end else if (gate) begin
                                    if (count_q == {{(CNT_W-2){1'b0}}, 2'd2}) begin
                                        out_q   <= ~out_q;
                                        count_q <= out_q ? lo_val : hi_val;
                                        null_q  <= 1'b0;
                                    end else begin
                                        count_q <= dec2;
                                    end
                                end
                            end
                        endcase
                    end
                endcase
            end
        end
    end

    AST_NULL_CLEARED_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_LOAD && tick && !cfg_wr && !val_wr) |=> !null_cnt); // R5
    AST_MODE0_LOW_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && !cfg_wr && mode == M_TC) |=> !out); // R6
    AST_MODE0_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode == M_TC && out && !cfg_wr && !val_wr) |=> out); // R6
    AST_MODE2_SINGLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode == M_RATE && !out && tick && gate && !trig_q && !cfg_wr && !val_wr) |=> out); // R8
endmodule

// File: rtl/ctr_channel.sv
module ctr_channel
    import ctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              gate,
    input  logic              ctl_wr,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              out
);
    logic             gate_rise;
    logic             cfg_wr;
    logic [1:0]       mode_lo;
    logic             bcd;
    logic             val_wr;
    logic [CNT_W-1:0] val;
    logic [CNT_W-1:0] count;
    logic             null_cnt;

    ctr_gate_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate),
        .rise  (gate_rise)
    );

    ctr_access u_access (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd),
        .din      (din),
        .count    (count),
        .out      (out),
        .null_cnt (null_cnt),
        .cfg_wr   (cfg_wr),
        .mode_lo  (mode_lo),
        .bcd      (bcd),
        .val_wr   (val_wr),
        .val      (val),
        .dout     (dout)
    );

    ctr_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .gate      (gate),
        .gate_rise (gate_rise),
        .cfg_wr    (cfg_wr),
        .cfg_mode  (din[2:1]),
        .mode      (mode_lo),
        .bcd       (bcd),
        .val_wr    (val_wr),
        .val       (val),
        .count     (count),
        .out       (out),
        .null_cnt  (null_cnt)
    );
endmodule

// File: tb/sim_ctr_channel.sv
`timescale 1ns/1ps
module sim_ctr_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       gate = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       dat_wr = 1'b0;
    logic       dat_rd = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] b, b2;

    ctr_channel u0 (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .gate(gate),
        .ctl_wr(ctl_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
        .din(din), .dout(dout), .out(out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_c(input logic [7:0] v);
        @(negedge clk); din = v; ctl_wr = 1'b1;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_d(input logic [7:0] v);
        @(negedge clk); din = v; dat_wr = 1'b1;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic rd_b(output logic [7:0] v);
        @(negedge clk); v = dout; dat_rd = 1'b1;
        @(negedge clk); dat_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_tick = 1'b1;
            @(negedge clk); cnt_tick = 1'b0;
        end
    endtask

    task automatic set_gate(input logic v);
        @(negedge clk); gate = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int to_bcd(input int v);
        return ((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 + ((v / 10) % 10) * 16 + (v % 10);
    endfunction

    function automatic int exp_rate_out(input int n, input int k);
        return ((k % n) == n - 1) ? 0 : 1;
    endfunction

    function automatic int exp_sq_out(input int n, input int k);
        return ((k % n) < (n + 1) / 2) ? 1 : 0;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED_0123);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 out after reset", out, 1);
        chk("R11 count after reset", dout, 8'h00);
        wr_c(8'hE2); rd_b(b);
        chk("R5 status after reset", b, 8'h80);

        // R1 pair access, gate low halts (R10)
        wr_c(8'h30); wr_d(8'h34); wr_d(8'h12);
        chk("R6 out low after write", out, 0);
        ticks(1); ticks(3);
        rd_b(b); rd_b(b2);
        chk("R1 pair low byte", b, 8'h34);
        chk("R10 pair high byte, halted", b2, 8'h12);

        // R1 low only / high only
        wr_c(8'h10); wr_d(8'h56); ticks(1); rd_b(b);
        chk("R1 low-only access", b, 8'h56);
        wr_c(8'h20); wr_d(8'h07); ticks(1); rd_b(b);
        chk("R1 high-only access", b, 8'h07);
        wr_c(8'h30); rd_b(b); rd_b(b2);
        chk("R1 high-only load zeroes low byte", b, 8'h00);
        chk("R1 high-only load high byte", b2, 8'h07);

        // R3 latch freeze and ignored second latch
        set_gate(1'b1);
        wr_c(8'h30); wr_d(8'd100); wr_d(8'h00);
        ticks(1); ticks(5);
        wr_c(8'h00);
        ticks(10);
        wr_c(8'h00);
        rd_b(b); rd_b(b2);
        chk("R3 latched low byte", b, 95);
        chk("R3 latched high byte", b2, 0);
        rd_b(b); rd_b(b2);
        chk("R3 live after latch drained", b, 85);

        // R6 mode 0 timing
        wr_c(8'h30); wr_d(8'd4); wr_d(8'h00);
        chk("R6 low after write", out, 0);
        ticks(1); ticks(3);
        chk("R6 still low at N-1", out, 0);
        ticks(1);
        chk("R6 high at N", out, 1);
        ticks(2);
        chk("R6 stays high", out, 1);

        // R2 BCD
        wr_c(8'h31); wr_d(8'h10); wr_d(8'h00);
        ticks(1); ticks(1);
        rd_b(b); rd_b(b2);
        chk("R2 bcd 10 -> 09 low", b, 8'h09);
        chk("R2 bcd 10 -> 09 high", b2, 8'h00);

        // R4/R5 readback
        wr_c(8'h34); wr_d(8'h03); wr_d(8'h02);
        wr_c(8'hE2); rd_b(b);
        chk("R5 status null before load", b, 8'hF4);
        ticks(1); ticks(3);
        wr_c(8'hC2);
        ticks(2);
        rd_b(b);
        chk("R4 readback status first", b, 8'hB4);
        rd_b(b);
        chk("R4 readback low second", b, 8'h00);
        rd_b(b);
        chk("R4 readback high third", b, 8'h02);

        // R8 mode 2 waveform
        wr_c(8'h34); wr_d(8'd5); wr_d(8'h00);
        ticks(1);
        for (int k = 1; k <= 12; k++) begin
            ticks(1);
            chk("R8 rate output", out, exp_rate_out(5, k));
        end

        // R9 mode 3, odd and even
        for (int n = 5; n <= 6; n++) begin
            wr_c(8'h36); wr_d(8'(n)); wr_d(8'h00);
            ticks(1);
            chk("R9 square high at load", out, 1);
            for (int k = 1; k <= 15; k++) begin
                ticks(1);
                chk("R9 square output", out, exp_sq_out(n, k));
            end
        end

        // R7 one-shot with retrigger
        set_gate(1'b0);
        wr_c(8'h32); wr_d(8'd3); wr_d(8'h00);
        ticks(2);
        chk("R7 no trigger keeps high", out, 1);
        set_gate(1'b1);
        ticks(1);
        chk("R7 low after trigger", out, 0);
        ticks(2);
        chk("R7 low before end", out, 0);
        set_gate(1'b0); set_gate(1'b1);
        ticks(1); ticks(2);
        chk("R7 retrigger extends low", out, 0);
        ticks(1);
        chk("R7 high after retriggered N", out, 1);

        // R10 mode 2 gate halt and reload
        wr_c(8'h34); wr_d(8'd20); wr_d(8'h00);
        ticks(1); ticks(3);
        set_gate(1'b0);
        ticks(4);
        wr_c(8'h00); rd_b(b); rd_b(b2);
        chk("R10 gate low halts", b, 17);
        set_gate(1'b1);
        ticks(1);
        wr_c(8'h00); rd_b(b); rd_b(b2);
        chk("R10 gate rise reloads", b, 20);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int sel, n, k, e, nv;
            sel = int'($urandom % 3);
            n = 8 + int'($urandom % 200);
            if (sel == 2) k = int'($urandom % (3 * n));
            else          k = int'($urandom % (n - 1));
            if (sel == 0)      begin wr_c(8'h30); nv = n;         e = n - k; end
            else if (sel == 1) begin wr_c(8'h31); nv = to_bcd(n); e = to_bcd(n - k); end
            else               begin wr_c(8'h34); nv = n;         e = n - (k % n); end
            wr_d(8'(nv)); wr_d(8'(nv >> 8));
            ticks(1); ticks(k);
            wr_c(8'h00); rd_b(b); rd_b(b2);
            if (sel == 1) chk("R2 random bcd count", {b2, b}, e);
            else if (sel == 2) chk("R8 random rate count", {b2, b}, e);
            else chk("R3 random latched count", {b2, b}, e);
        end

        summary();
        $finish;
    end
endmodule